// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single input line and hands each finished character to a CPU. A two-flop synchronizer conditions the line. The block then looks for a falling edge and confirms a start bit at the middle of that bit. It takes in the data bits least significant bit first, then an optional parity bit and one stop bit. Each bit is sampled once at its midpoint, and the bit period is set by a divisor input counted in clock cycles.

When the stop bit has been sampled, the assembled character moves into a separate holding register. The CPU reads the character from there while the next one is already arriving. A ready flag and an active-high interrupt request announce new data. The parity and framing errors belong to the character and are captured with it. A sticky overrun flag records that a character was overwritten before the CPU read it.

The CPU reaches the block through a simple read port. One select value returns the character and the other returns the status word. Reading the character clears the ready flag, and reading the status word clears the overrun flag.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, the ready, overrun, parity-error and framing-error flags are 0, `irq_o` is 0, and a character read returns 0.
- R2: A frame is a low start bit, then DATA_W data bits sent least significant bit first, then one even parity bit, then a high stop bit. Each bit lasts `divisor_i` clock cycles. Once the stop bit is sampled, the data moves into the holding register and the ready flag sets.
- R3: A read with `rd_en_i`=1 and `rd_sel_i`=0 returns the held character in bits [DATA_W-1:0] with the upper bits at zero. It clears the ready flag on the next clock, unless a new character completes in that same cycle.
- R4: `irq_o` is high exactly while the ready flag is set.
- R5: The holding register keeps its character unchanged while a following character is being shifted in, until that character completes.
- R6: When a character completes while ready is still set and no character read happens in that cycle, the holding register is overwritten and the overrun flag (status bit 1) sets. The overrun flag stays set until a status read (`rd_en_i`=1, `rd_sel_i`=1).
- R7: The parity-error flag (status bit 2) is loaded with each character. It is 1 when the received parity bit differs from the XOR of the data bits.
- R8: The framing-error flag (status bit 3) is loaded with each character and is 1 when the stop bit is sampled low. A line that then stays low produces no further character until a new falling edge.
- R9: A low pulse that is high again at the middle of the start bit is discarded, and no character is delivered.
- R10: The status word has ready at bit 0, overrun at bit 1, parity error at bit 2 and framing error at bit 3. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rxd_i | input | 1 | Serial receive line, idle high |
| divisor_i | input | DIV_W | Clock cycles per bit |
| rd_en_i | input | 1 | Read strobe for the register read port |
| rd_sel_i | input | 1 | 0 selects the character, 1 selects the status word |
| rd_data_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request, high while a character is waiting |

## Verification
The main function is driven in four ways. Random characters at two divisors, one of them odd, show that the bit order and mid-bit sampling are right across timing. Random injection of bad parity and a low stop bit shows that each error flag is tied to its own character and does not leak into the next one. Directed cases cover the remaining behaviour: two back-to-back unread characters (overrun set, then cleared by a status read), a read issued while a second character is half received (the holding register is stable), a short low glitch (rejected), and a line held low for many bit times (exactly one framing-error character).

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned ST_RDY  = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_PERR = 2;
  localparam int unsigned ST_FERR = 3;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DIV_W      = 16,
  parameter bit          PARITY_EN  = 1'b1,
  parameter bit          PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  divisor_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int unsigned      BIT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(DATA_W - 1);
  localparam rx_state_e        AFTER_DATA = PARITY_EN ? RX_PAR : RX_STOP;

  rx_state_e         st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d, limit;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              prev_q;
  logic              tick, fall, exp_par;

  assign fall  = prev_q & ~rxd_i;
  assign limit = (st_q == RX_START) ? (divisor_i >> 1) : divisor_i;
  assign tick  = (cnt_q == limit - DIV_W'(1));

  generate
    if (PARITY_EN) begin : g_par
      assign exp_par = (^sh_q) ^ PARITY_ODD;
      assign perr_o  = par_q ^ exp_par;
    end else begin : g_nopar
      assign exp_par = 1'b0;
      assign perr_o  = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + DIV_W'(1);
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    done_o = 1'b0;
    case (st_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (fall) st_d = RX_START;
      end
      RX_START: if (tick) begin
        cnt_d = '0;
        bit_d = '0;
        st_d  = rxd_i ? RX_IDLE : RX_DATA;
      end
      RX_DATA: if (tick) begin
        cnt_d = '0;
        sh_d  = {rxd_i, sh_q[DATA_W-1:1]};
        if (bit_q == LAST_BIT) st_d = AFTER_DATA;
        else                   bit_d = bit_q + BIT_W'(1);
      end
      RX_PAR: if (tick) begin
        cnt_d = '0;
        par_d = rxd_i;
        st_d  = RX_STOP;
      end
      RX_STOP: if (tick) begin
        cnt_d  = '0;
        done_o = 1'b1;
        st_d   = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      prev_q <= rxd_i;
    end
  end

  assign data_o = sh_q;
  assign ferr_o = ~rxd_i;
endmodule

// File: rtl/uart_rx_holdreg.sv
module uart_rx_holdreg
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              rdy_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              rdy_q, rdy_d, ovr_q, ovr_d;
  logic              perr_q, perr_d, ferr_q, ferr_d;
  logic              rd_char, rd_stat;

  assign rd_char = rd_en_i & ~rd_sel_i;
  assign rd_stat = rd_en_i &  rd_sel_i;

  always_comb begin
    hold_d = load_i ? data_i : hold_q;
    perr_d = load_i ? perr_i : perr_q;
    ferr_d = load_i ? ferr_i : ferr_q;
    rdy_d  = load_i | (rdy_q & ~rd_char);
    ovr_d  = (load_i & rdy_q & ~rd_char) | (ovr_q & ~rd_stat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i) begin
      rd_data_o[ST_RDY]  = rdy_q;
      rd_data_o[ST_OVR]  = ovr_q;
      rd_data_o[ST_PERR] = perr_q;
      rd_data_o[ST_FERR] = ferr_q;
    end else begin
      rd_data_o[DATA_W-1:0] = hold_q;
    end
  end

  assign hold_o = hold_q;
  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DIV_W      = 16,
  parameter bit          PARITY_EN  = 1'b1,
  parameter bit          PARITY_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  output logic [15:0]      rd_data_o,
  output logic             irq_o
);
  logic              rst_sync_n;
  logic              rxd_s;
  logic              char_done;
  logic [DATA_W-1:0] shift_data;
  logic              shift_perr, shift_ferr;
  logic [DATA_W-1:0] hold_data;
  logic              rdy_flag, ovr_flag;

  uart_rx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  uart_rx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_rx_shifter #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
  ) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .rxd_i(rxd_s), .divisor_i(divisor_i),
    .done_o(char_done), .data_o(shift_data), .perr_o(shift_perr), .ferr_o(shift_ferr)
  );

  uart_rx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load_i(char_done), .data_i(shift_data),
    .perr_i(shift_perr), .ferr_i(shift_ferr), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .hold_o(hold_data), .rdy_o(rdy_flag), .ovr_o(ovr_flag)
  );

  assign irq_o = rdy_flag;
endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic              rd_sel_i,
  input logic [15:0]       rd_data_o,
  input logic              irq_o,
  input logic              char_done,
  input logic [DATA_W-1:0] hold_data,
  input logic              ovr_flag
);
  // R2: a completed character raises the request on the next clock
  p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> irq_o);

  // R3: a character read without a coinciding completion drops ready
  p_read_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_sel_i && !char_done) |=> !irq_o);

  // R4: status bit 0 seen on a status read agrees with the request line
  p_irq_matches_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_sel_i) |-> (rd_data_o[0] == irq_o));

  // R5: holding register changes only on a completion
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(hold_data));

  // R6: unread character overwritten sets overrun
  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && irq_o && !(rd_en_i && !rd_sel_i)) |=> ovr_flag);

  // R6: overrun is sticky until a status read
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !(rd_en_i && rd_sel_i)) |=> ovr_flag);
endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .char_done(char_done),
  .hold_data(hold_data), .ovr_flag(ovr_flag)
);

// File: tb/sim_uart_rx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_rx_dbuf;
  localparam int DW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] divisor = 16'd16;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_rx_dbuf #(.DATA_W(DW), .DIV_W(16), .PARITY_EN(1'b1), .PARITY_ODD(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .divisor_i(divisor),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [15:0] stat_word(bit rdy, bit ovr, bit perr, bit ferr);
    return {12'd0, ferr, perr, ovr, rdy};
  endfunction

  function automatic logic even_par(logic [DW-1:0] d);
    return ^d;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold_line(logic v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(logic [DW-1:0] d, bit bad_par, bit bad_stop);
    hold_line(1'b0, divisor);
    for (int i = 0; i < DW; i++) hold_line(d[i], divisor);
    hold_line(even_par(d) ^ bad_par, divisor);
    hold_line(~bad_stop, divisor);
    hold_line(1'b1, 2);
  endtask

  task automatic read_reg(bit sel, output logic [15:0] val);
    rd_sel = sel;
    rd_en = 1'b1;
    #1 val = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    rd_sel = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    logic [DW-1:0] a, b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    read_reg(1'b1, v); check("R1 status", v, 16'd0);
    read_reg(1'b0, v); check("R1 data", v, 16'd0);

    // R2 R7 R8 R10 random frames at two divisors
    for (int n = 0; n < 45; n++) begin
      logic [DW-1:0] d;
      bit bp, bs;
      if (n == 30) divisor = 16'd11;
      d  = DW'($urandom);
      bp = ($urandom % 5) == 0;
      bs = ($urandom % 6) == 0;
      send_frame(d, bp, bs);
      check("R4 irq after frame", {15'd0, irq}, 16'd1);
      read_reg(1'b1, v); check("R2/R7/R8/R10 status", v, stat_word(1, 0, bp, bs));
      read_reg(1'b0, v); check("R2/R3 data", v, {8'd0, d});
      read_reg(1'b1, v); check("R3 ready cleared, errors kept", v, stat_word(0, 0, bp, bs));
    end
    divisor = 16'd16;

    // R6 overrun: two unread characters
    a = 8'hA5; b = 8'h3C;
    send_frame(a, 0, 0);
    send_frame(b, 0, 0);
    read_reg(1'b1, v); check("R6 overrun set", v, stat_word(1, 1, 0, 0));
    read_reg(1'b0, v); check("R6 newest data kept", v, {8'd0, b});
    read_reg(1'b1, v); check("R6 overrun cleared by status read", v, 16'd0);

    // R5 holding register stable while next character arrives
    a = 8'h81; b = 8'h7E;
    send_frame(a, 0, 0);
    hold_line(1'b0, divisor);
    for (int i = 0; i < 4; i++) hold_line(b[i], divisor);
    read_reg(1'b0, v); check("R5 old data during reception", v, {8'd0, a});
    for (int i = 4; i < DW; i++) hold_line(b[i], divisor);
    hold_line(even_par(b), divisor);
    hold_line(1'b1, divisor + 2);
    read_reg(1'b1, v); check("R5 no overrun after read", v, stat_word(1, 0, 0, 0));
    read_reg(1'b0, v); check("R5 new data", v, {8'd0, b});

    // R9 glitch rejection
    hold_line(1'b0, 3);
    hold_line(1'b1, 14 * 16);
    read_reg(1'b1, v); check("R9 glitch discarded", v, 16'd0);
    check("R9 irq low", {15'd0, irq}, 16'd0);

    // R8 line held low: exactly one framing-error character
    hold_line(1'b0, 30 * 16);
    read_reg(1'b1, v); check("R8 break framing", v, stat_word(1, 0, 0, 1));
    read_reg(1'b0, v); check("R8 break data", v, 16'd0);
    hold_line(1'b0, 20 * 16);
    read_reg(1'b1, v); check("R8 no repeat while low", v, stat_word(0, 0, 0, 1));
    hold_line(1'b1, 3 * 16);

    // R7 parity error then clean character clears it
    send_frame(8'h5A, 1, 0);
    read_reg(1'b1, v); check("R7 parity error", v, stat_word(1, 0, 1, 0));
    read_reg(1'b0, v); check("R7 data with parity error", v, 16'h005A);
    send_frame(8'h5A, 0, 0);
    read_reg(1'b1, v); check("R7 parity error replaced", v, stat_word(1, 0, 0, 0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule